// File: doc/BRIEF.md
# Bus Region Decoder with Wait-State Sequencer

This block sits between a 32-bit processor bus and a set of memory regions. Each access arrives as a one-cycle request that carries the address, the access size, the direction and the current program counter. The block finds the addressed region and folds mirrored addresses down to a local offset within that region. It decides whether the access is sequential, meaning it directly follows the previous completed access. It then holds the bus for the correct number of cycles before it pulses `ready`. Accesses with a width the region does not accept are rejected. Reads of the protected boot ROM are also blocked unless the program counter is itself inside the boot ROM.

A three-state machine controls the timing. In S_IDLE a request is accepted. When the wait count is zero the machine takes the zero-wait transition straight to S_DONE. Otherwise it takes the wait transition to S_WAIT, where it counts down once per cycle. On the last count it takes the expiry transition to S_DONE. S_DONE drives `ready` for one cycle and then takes the release transition back to S_IDLE. The request fields are captured when the request is accepted. The decoded results stay on the outputs until the next request is accepted.

Top module: `memmap_wait_decoder`

## Requirements
- R1: `region_sel` encodes the region picked by address bits [27:24] when bits [31:28] are zero. The codes are: 0 boot ROM (window 0x0), 2 external RAM (0x2), 3 work RAM (0x3), 4 I/O (0x4), 5 palette (0x5), 6 video RAM (0x6), 7 sprite attribute RAM (0x7), 8 cartridge ROM (0x8 to 0xD), 9 EEPROM and 10 cartridge RAM (0xE to 0xF). Window 0x1, and any address with a nonzero bit in [31:28], give code 1 (unmapped). Unmapped accesses return zero and never write.
- R2: `local_off` is the address modulo the region size. The sizes are: boot ROM 0x4000, external RAM 0x40000, work RAM 0x8000, palette and sprite RAM 0x400 each, cartridge RAM 0x10000. Cartridge ROM and EEPROM use address bits [24:0]. I/O uses bits [23:0]. Unmapped gives 0.
- R3: In video RAM the offset is address bits [16:0]. If that value is 0x18000 or more, 0x8000 is subtracted from it.
- R4: The access goes to the EEPROM (code 9) when `eeprom_present` is high, the window is 0x8 to 0xD, and address bits 24 and 23 are both 1. An EEPROM read returns only `mem_rdata` bit 0 in bit 0 and zeros in all other bits.
- R5: An access is sequential (`seq_acc`=1) when its address equals the previous completed access address plus 2 or plus 4. The stored address is updated each time `ready` pulses. The first access after reset is non-sequential.
- R6: Boot ROM, work RAM, I/O, palette, video RAM, sprite RAM and unmapped accesses take one cycle. External RAM takes three cycles. An access that takes N cycles has `ready` high N clock edges after the accepting edge.
- R7: Cartridge ROM and EEPROM accesses take 1+`crom_wait_s` cycles when sequential and 1+`crom_wait_n` cycles otherwise. Cartridge RAM uses `cram_wait_s` and `cram_wait_n` in the same way.
- R8: `req_size` is 0 for byte, 1 for halfword, 2 for word; 3 is always illegal. Palette, video and sprite RAM reject size 0, and cartridge RAM rejects every size except 0. A rejected access takes one cycle, pulses `width_err` with `ready`, never asserts `mem_we`, and returns zero.
- R9: A legal-width read of the boot ROM while `cpu_pc` is 0x4000 or above returns zero and pulses `prot_err` with `ready`. When `cpu_pc` is below 0x4000 the read returns `mem_rdata`. A width fault takes priority over a protection fault.
- R10: `ready` is high for exactly one cycle per access. `mem_we` is high only with `ready`, and only for a legal write to a mapped region other than the boot ROM. `rd_data` is zero except with `ready` on a legal read.
- R11: After reset, `ready`, `mem_we`, `width_err`, `prot_err`, `seq_acc` and `rd_data` are 0, and `region_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe, taken only while idle |
| req_addr | input | 32 | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_write | input | 1 | 1 for write, 0 for read |
| cpu_pc | input | 32 | Program counter at the time of the request |
| eeprom_present | input | 1 | Turns on the EEPROM overlay in the cartridge ROM windows |
| crom_wait_n | input | 4 | Extra cycles for a non-sequential cartridge ROM access |
| crom_wait_s | input | 4 | Extra cycles for a sequential cartridge ROM access |
| cram_wait_n | input | 4 | Extra cycles for a non-sequential cartridge RAM access |
| cram_wait_s | input | 4 | Extra cycles for a sequential cartridge RAM access |
| mem_rdata | input | 32 | Read data from the selected region |
| ready | output | 1 | One-cycle completion pulse |
| region_sel | output | 4 | Code of the decoded region |
| local_off | output | 25 | Offset within the region after mirror folding |
| seq_acc | output | 1 | The access was classified as sequential |
| mem_we | output | 1 | Write strobe toward the region |
| rd_data | output | 32 | Read data returned to the bus |
| width_err | output | 1 | Illegal-width pulse |
| prot_err | output | 1 | Blocked boot ROM read pulse |

## Verification
Two checks can apply to the same access: the width rule and the boot ROM protection rule. Both apply when the boot ROM is read with size 3 while the program counter is outside the boot ROM. Directed accesses and random ones with the program counter outside the ROM produce this case. The expected result is a `width_err` pulse with no `prot_err` and zero read data. Sequential classification and the cartridge wait counts also act together. An address stepped by +2 or +4 from the previous access must select the sequential count, and the bench checks this by counting cycles until `ready`, with different sequential and non-sequential counts applied.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 25;
    localparam int WAIT_W = 4;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_BAD  = 2'd3;

    typedef enum logic [3:0] {
        RG_BOOT = 4'd0,
        RG_NONE = 4'd1,
        RG_EXT  = 4'd2,
        RG_WORK = 4'd3,
        RG_IO   = 4'd4,
        RG_PAL  = 4'd5,
        RG_VRAM = 4'd6,
        RG_OAM  = 4'd7,
        RG_CROM = 4'd8,
        RG_EEP  = 4'd9,
        RG_CRAM = 4'd10
    } region_e;

    typedef struct packed {
        region_e             region;
        logic [OFF_W-1:0]    off;
        logic [ADDR_W-1:0]   addr;
        logic                seq;
        logic                rd_ok;
        logic                we_ok;
        logic                wfault;
        logic                pfault;
    } access_t;

endpackage

// File: rtl/region_decoder.sv
module region_decoder
    import memmap_pkg::*;
#(
    parameter int BOOT_BYTES = 32'h4000,
    parameter int EXT_BYTES  = 32'h40000,
    parameter int WORK_BYTES = 32'h8000,
    parameter int PAL_BYTES  = 32'h400,
    parameter int VRAM_BYTES = 32'h18000,
    parameter int VRAM_WIN   = 32'h20000,
    parameter int OAM_BYTES  = 32'h400,
    parameter int CRAM_BYTES = 32'h10000,
    parameter int EXT_WAIT   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              write,
    input  logic [ADDR_W-1:0] pc,
    input  logic              eeprom_present,
    input  logic              seq,
    input  logic [WAIT_W-1:0] crom_n,
    input  logic [WAIT_W-1:0] crom_s,
    input  logic [WAIT_W-1:0] cram_n,
    input  logic [WAIT_W-1:0] cram_s,
    output access_t           acc,
    output logic [WAIT_W-1:0] wait_cyc
);

    localparam logic [ADDR_W-1:0] BOOT_M = ADDR_W'(BOOT_BYTES - 1);
    localparam logic [ADDR_W-1:0] EXT_M  = ADDR_W'(EXT_BYTES - 1);
    localparam logic [ADDR_W-1:0] WORK_M = ADDR_W'(WORK_BYTES - 1);
    localparam logic [ADDR_W-1:0] PAL_M  = ADDR_W'(PAL_BYTES - 1);
    localparam logic [ADDR_W-1:0] OAM_M  = ADDR_W'(OAM_BYTES - 1);
    localparam logic [ADDR_W-1:0] CRAM_M = ADDR_W'(CRAM_BYTES - 1);
    localparam logic [ADDR_W-1:0] VWIN_M = ADDR_W'(VRAM_WIN - 1);
    localparam logic [ADDR_W-1:0] VFOLD  = ADDR_W'(VRAM_WIN - VRAM_BYTES);

    logic [3:0]        win;
    logic [ADDR_W-1:0] vram_off;
    logic              pc_in_boot;

    assign win        = addr[27:24];
    assign pc_in_boot = (pc < ADDR_W'(BOOT_BYTES));

    always_comb begin
        vram_off = addr & VWIN_M;
        if (vram_off >= ADDR_W'(VRAM_BYTES)) begin
            vram_off = vram_off - VFOLD;
        end
    end

    always_comb begin
        acc        = '0;
        acc.addr   = addr;
        acc.seq    = seq;
        acc.region = RG_NONE;
        wait_cyc   = '0;
        if (addr[31:28] == 4'h0) begin
            unique case (win)
                4'h0: begin
                    acc.region = RG_BOOT;
                    acc.off    = OFF_W'(addr & BOOT_M);
                end
                4'h1: acc.region = RG_NONE;
                4'h2: begin
                    acc.region = RG_EXT;
                    acc.off    = OFF_W'(addr & EXT_M);
                    wait_cyc   = WAIT_W'(EXT_WAIT);
                end
                4'h3: begin
                    acc.region = RG_WORK;
                    acc.off    = OFF_W'(addr & WORK_M);
                end
                4'h4: begin
                    acc.region = RG_IO;
                    acc.off    = OFF_W'(addr[23:0]);
                end
                4'h5: begin
                    acc.region = RG_PAL;
                    acc.off    = OFF_W'(addr & PAL_M);
                end
                4'h6: begin
                    acc.region = RG_VRAM;
                    acc.off    = OFF_W'(vram_off);
                end
                4'h7: begin
                    acc.region = RG_OAM;
                    acc.off    = OFF_W'(addr & OAM_M);
                end
                4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD: begin
                    acc.region = (eeprom_present && addr[24] && addr[23]) ? RG_EEP : RG_CROM;
                    acc.off    = addr[OFF_W-1:0];
                    wait_cyc   = seq ? crom_s : crom_n;
                end
                4'hE, 4'hF: begin
                    acc.region = RG_CRAM;
                    acc.off    = OFF_W'(addr & CRAM_M);
                    wait_cyc   = seq ? cram_s : cram_n;
                end
                default: acc.region = RG_NONE;
            endcase
        end

        // width legality per region
        if (size == SZ_BAD) begin
            acc.wfault = 1'b1;
        end else if (acc.region == RG_PAL || acc.region == RG_VRAM || acc.region == RG_OAM) begin
            acc.wfault = (size == SZ_BYTE);
        end else if (acc.region == RG_CRAM) begin
            acc.wfault = (size != SZ_BYTE);
        end

        if (acc.wfault) begin
            wait_cyc = '0;
        end

        acc.pfault = !acc.wfault && !write && (acc.region == RG_BOOT) && !pc_in_boot;
        acc.rd_ok  = !write && !acc.wfault && !acc.pfault && (acc.region != RG_NONE);
        acc.we_ok  = write && !acc.wfault && (acc.region != RG_NONE) && (acc.region != RG_BOOT);
    end

endmodule

// File: rtl/seq_tracker.sv
module seq_tracker
    import memmap_pkg::*;
#(
    parameter int STEP_A = 2,
    parameter int STEP_B = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              commit,
    input  logic [ADDR_W-1:0] commit_addr,
    output logic              seq_now
);

    logic [ADDR_W-1:0] prev_addr;
    logic              prev_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_addr  <= '0;
            prev_valid <= 1'b0;
        end else if (commit) begin
            prev_addr  <= commit_addr;
            prev_valid <= 1'b1;
        end
    end

    assign seq_now = prev_valid &&
                     ((cur_addr == prev_addr + ADDR_W'(STEP_A)) ||
                      (cur_addr == prev_addr + ADDR_W'(STEP_B)));

    AST_FIRST_NONSEQ: assert property (@(posedge clk) disable iff (!rst_n)
        !prev_valid |-> !seq_now); // R5

    AST_TRACK_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (prev_valid && prev_addr == $past(commit_addr))); // R5

endmodule

// File: rtl/access_fsm.sv
module access_fsm
    import memmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WAIT_W-1:0] wait_cyc,
    output logic              idle,
    output logic              done
);

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_DONE = 2'd2
    } st_e;

    st_e               st, st_nx;
    logic [WAIT_W-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= S_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            S_IDLE: begin
                if (start) begin
                    if (wait_cyc == '0) begin
                        st_nx = S_DONE;
                    end else begin
                        st_nx  = S_WAIT;
                        cnt_nx = wait_cyc;
                    end
                end
            end
            S_WAIT: begin
                cnt_nx = cnt - 1'b1;
                if (cnt == WAIT_W'(1)) begin
                    st_nx = S_DONE;
                end
            end
            S_DONE:  st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_comb begin
        idle = (st == S_IDLE);
        done = (st == S_DONE);
    end

    AST_WAIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT) |-> (cnt != '0)); // R7

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_ZERO_WAIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && wait_cyc == '0) |=> done); // R6

endmodule

// File: rtl/memmap_wait_decoder.sv
module memmap_wait_decoder
    import memmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       cpu_pc,
    input  logic              eeprom_present,
    input  logic [3:0]        crom_wait_n,
    input  logic [3:0]        crom_wait_s,
    input  logic [3:0]        cram_wait_n,
    input  logic [3:0]        cram_wait_s,
    input  logic [31:0]       mem_rdata,
    output logic              ready,
    output logic [3:0]        region_sel,
    output logic [24:0]       local_off,
    output logic              seq_acc,
    output logic              mem_we,
    output logic [31:0]       rd_data,
    output logic              width_err,
    output logic              prot_err
);

    access_t           dec_acc;
    access_t           lat;
    logic [WAIT_W-1:0] dec_wait;
    logic              seq_now;
    logic              idle;
    logic              done;
    logic              start;

    assign start = req_valid && idle;

    seq_tracker u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_addr    (req_addr),
        .commit      (done),
        .commit_addr (lat.addr),
        .seq_now     (seq_now)
    );

    region_decoder u_dec (
        .addr           (req_addr),
        .size           (req_size),
        .write          (req_write),
        .pc             (cpu_pc),
        .eeprom_present (eeprom_present),
        .seq            (seq_now),
        .crom_n         (crom_wait_n),
        .crom_s         (crom_wait_s),
        .cram_n         (cram_wait_n),
        .cram_s         (cram_wait_s),
        .acc            (dec_acc),
        .wait_cyc       (dec_wait)
    );

    access_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .wait_cyc (dec_wait),
        .idle     (idle),
        .done     (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat        <= '0;
            lat.region <= RG_NONE;
        end else if (start) begin
            lat <= dec_acc;
        end
    end

    always_comb begin
        ready      = done;
        region_sel = lat.region;
        local_off  = lat.off;
        seq_acc    = lat.seq;
        mem_we     = done && lat.we_ok;
        width_err  = done && lat.wfault;
        prot_err   = done && lat.pfault;
        rd_data    = '0;
        if (done && lat.rd_ok) begin
            rd_data = (lat.region == RG_EEP) ? {31'b0, mem_rdata[0]} : mem_rdata;
        end
    end

    AST_WIDTH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        width_err |-> (!mem_we && rd_data == '0)); // R8

    AST_PROT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> (rd_data == '0 && !width_err)); // R9

    AST_FAULT_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (width_err || prot_err || mem_we) |-> ready); // R10

    AST_EEP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (region_sel == RG_EEP) |-> (rd_data[31:1] == '0)); // R4

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (region_sel == RG_NONE) |-> (!mem_we && rd_data == '0)); // R1

endmodule

// File: tb/test_memmap_wait_decoder.sv
`timescale 1ns/1ps
module test_memmap_wait_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] cpu_pc = '0;
    logic        eeprom_present = 1'b0;
    logic [3:0]  crom_wait_n = 4'd4, crom_wait_s = 4'd1;
    logic [3:0]  cram_wait_n = 4'd5, cram_wait_s = 4'd3;
    logic [31:0] mem_rdata = 32'hA5C3_9E17;
    logic        ready, seq_acc, mem_we, width_err, prot_err;
    logic [3:0]  region_sel;
    logic [24:0] local_off;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    logic [31:0] m_prev = '0;
    bit          m_prev_v = 0;

    always #5 clk = ~clk;

    memmap_wait_decoder i_memmap_wait_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .cpu_pc(cpu_pc),
        .eeprom_present(eeprom_present), .crom_wait_n(crom_wait_n),
        .crom_wait_s(crom_wait_s), .cram_wait_n(cram_wait_n),
        .cram_wait_s(cram_wait_s), .mem_rdata(mem_rdata), .ready(ready),
        .region_sel(region_sel), .local_off(local_off), .seq_acc(seq_acc),
        .mem_we(mem_we), .rd_data(rd_data), .width_err(width_err), .prot_err(prot_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] f_region(input logic [31:0] a, input bit eep);
        logic [3:0] w = a[27:24];
        if (a[31:28] != 0) return 4'd1;
        if (w >= 4'h8 && w <= 4'hD) return (eep && a[24] && a[23]) ? 4'd9 : 4'd8;
        if (w >= 4'hE) return 4'd10;
        return w;
    endfunction

    function automatic logic [24:0] f_off(input logic [31:0] a, input logic [3:0] rg);
        logic [31:0] v;
        case (rg)
            4'd0:       v = a % 32'h4000;
            4'd2:       v = a % 32'h40000;
            4'd3:       v = a % 32'h8000;
            4'd4:       v = {8'h0, a[23:0]};
            4'd5, 4'd7: v = a % 32'h400;
            4'd6: begin
                v = {15'h0, a[16:0]};
                if (v >= 32'h18000) v = v - 32'h8000;
            end
            4'd8, 4'd9: v = {7'h0, a[24:0]};
            4'd10:      v = a % 32'h10000;
            default:    v = 0;
        endcase
        return v[24:0];
    endfunction

    function automatic bit f_badw(input logic [3:0] rg, input logic [1:0] sz);
        if (sz == 2'd3) return 1;
        if (rg == 4'd5 || rg == 4'd6 || rg == 4'd7) return sz == 2'd0;
        if (rg == 4'd10) return sz != 2'd0;
        return 0;
    endfunction

    // one access: drive, count cycles to ready, compare everything
    task automatic access(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                          input logic [31:0] pc, input string note);
        logic [3:0]  rg = f_region(a, eeprom_present);
        bit          sq = m_prev_v && (a == m_prev + 32'd2 || a == m_prev + 32'd4);
        bit          bw = f_badw(rg, sz);
        bit          pf = !bw && !wr && rg == 4'd0 && pc >= 32'h4000;
        bit          rok = !wr && !bw && !pf && rg != 4'd1;
        bit          wok = wr && !bw && rg != 4'd1 && rg != 4'd0;
        int          w = 0;
        int          n = 0;
        logic [31:0] ed;
        if (!bw) begin
            if (rg == 4'd2) w = 2;
            else if (rg == 4'd8 || rg == 4'd9) w = sq ? crom_wait_s : crom_wait_n;
            else if (rg == 4'd10) w = sq ? cram_wait_s : cram_wait_n;
        end
        ed = !rok ? 32'h0 : (rg == 4'd9 ? {31'h0, mem_rdata[0]} : mem_rdata);
        req_addr = a; req_size = sz; req_write = wr; cpu_pc = pc; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!ready && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk($sformatf("R6/R7 cycles %s", note), n, w + 1);
        chk($sformatf("R1 region %s", note), {28'h0, region_sel}, {28'h0, rg});
        chk($sformatf("R2/R3 offset %s", note), {7'h0, local_off}, {7'h0, f_off(a, rg)});
        chk($sformatf("R5 seq %s", note), {31'h0, seq_acc}, {31'h0, sq});
        chk($sformatf("R8 width_err %s", note), {31'h0, width_err}, {31'h0, bw});
        chk($sformatf("R9 prot_err %s", note), {31'h0, prot_err}, {31'h0, pf});
        chk($sformatf("R10 mem_we %s", note), {31'h0, mem_we}, {31'h0, wok});
        chk($sformatf("R4/R10 rd_data %s", note), rd_data, ed);
        m_prev = a; m_prev_v = 1;
        @(negedge clk);
        chk($sformatf("R10 ready pulse %s", note), {29'h0, ready, mem_we, |rd_data}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        process::self().srandom(32'h1234_5678);
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 reset outputs", {26'h0, ready, mem_we, width_err, prot_err, seq_acc, |rd_data}, 32'h0);
        chk("R11 reset region", {28'h0, region_sel}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        access(32'h0000_0002, 2'd1, 0, 32'h0000_0100, "first after reset at +2");
        access(32'h0000_0004, 2'd2, 0, 32'h0800_0000, "boot read pc outside");
        access(32'h0000_0008, 2'd2, 0, 32'h0000_3FFC, "boot read pc inside seq");
        access(32'h0000_0010, 2'd3, 0, 32'h0800_0000, "boot size3 both faults");
        access(32'h0204_0010, 2'd1, 1, 32'h0800_0000, "ext ram mirror write");
        access(32'h06018004, 2'd1, 0, 32'h0800_0000, "vram fold");
        access(32'h0601_7FFE, 2'd2, 1, 32'h0800_0000, "vram top legal");
        access(32'h0500_0400, 2'd0, 1, 32'h0800_0000, "palette byte write rejected");
        access(32'h0E01_2345, 2'd1, 1, 32'h0800_0000, "cart ram half rejected");
        access(32'h0F01_2345, 2'd0, 0, 32'h0800_0000, "cart ram byte mirror");
        access(32'h0800_0100, 2'd1, 0, 32'h0800_0000, "cart rom nonseq");
        access(32'h0800_0102, 2'd1, 0, 32'h0800_0000, "cart rom seq +2");
        access(32'h0800_0106, 2'd2, 0, 32'h0800_0000, "cart rom seq +4");
        access(32'h0800_0107, 2'd0, 0, 32'h0800_0000, "cart rom +1 nonseq");
        access(32'h1000_0000, 2'd2, 1, 32'h0800_0000, "unmapped high nibble");
        access(32'h0100_0000, 2'd2, 0, 32'h0800_0000, "unmapped window 1");
        eeprom_present = 1'b1;
        access(32'h0D80_0000, 2'd1, 0, 32'h0800_0000, "eeprom overlay");
        access(32'h0D00_0000, 2'd1, 0, 32'h0800_0000, "eeprom present a23 low");
        access(32'h0980_0010, 2'd1, 0, 32'h0800_0000, "eeprom lower window");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            logic [31:0] r = $urandom;
            if (i % 50 == 0) begin
                eeprom_present = $urandom % 2;
                crom_wait_n = $urandom % 9; crom_wait_s = $urandom % 5;
                cram_wait_n = $urandom % 9; cram_wait_s = $urandom % 5;
            end
            if (r % 10 < 3) a = m_prev + ((r[8]) ? 32'd4 : 32'd2);
            else if (r % 10 == 3) a = {($urandom % 2 == 0) ? 4'h1 : 4'h0, 4'($urandom), 24'($urandom)};
            else a = {4'h0, 4'($urandom), 24'($urandom)};
            mem_rdata = $urandom;
            access(a, 2'($urandom), 1'($urandom),
                   ($urandom % 2) ? {18'h0, 14'($urandom)} : $urandom | 32'h4000, "random");
        end

        ended = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule